// File: doc/BRIEF.md
# Bus Clock Prescaler Tree

This block turns one fast reference clock into a set of clock-enable strobes for a layered bus system. Three incoming enable streams stand for the candidate system clock sources: an internal oscillator, an external oscillator and a synthesized clock. A select field picks one of them as the system rate. A high-speed bus prescaler divides that rate by a power of two. Two peripheral bus prescalers each divide the high-speed bus strobe further. Each peripheral bus also has a timer strobe. The timer strobe runs at twice the peripheral bus rate whenever that bus prescaler divides. When the bus prescaler is at 1:1, the timer strobe matches the bus strobe.

Every output is a one-cycle enable pulse in the reference clock domain, not a derived clock. Downstream logic qualifies its registers with these pulses. All settings come from one 32-bit configuration word that is sampled continuously. A divider adopts a new setting only when its current period ends, so no enable interval is ever cut short. There is no data path, so every pin is a plain control signal and no back-pressure applies.

Top module: `busclk_prescale_tree`

## Requirements
- R1: Config bits 1:0 choose the system source. Code 0 picks `src_en[0]` (internal oscillator), code 1 picks `src_en[1]` (external oscillator) and code 2 picks `src_en[2]` (synthesized clock). A new code applies from the clock edge after it is presented.
- R2: Select code 3 is reserved. While it is present, the previously selected source stays in use.
- R3: The high-speed prescaler code sits in config bits 7:4. Codes 0 to 7 pass every system pulse through (divide by 1). Codes 8, 9, 10 and 11 emit one `hbus_en` pulse per 2, 4, 8 and 16 system pulses.
- R4: High-speed codes 12, 13, 14 and 15 divide by 64, 128, 256 and 512. No code gives divide-by-32.
- R5: The first peripheral prescaler code sits in bits 12:10 and the second in bits 15:13. Each counts `hbus_en` pulses. Codes 0 to 3 divide by 1, and codes 4, 5, 6 and 7 divide by 2, 4, 8 and 16.
- R6: When the top bit of a peripheral code is set (bit 12 or bit 15), that bus's timer strobe pulses twice per bus period. One of those pulses coincides with the bus pulse. When the top bit is clear, the timer strobe equals the bus strobe.
- R7: Each output is high for exactly one cycle per divided period, and only in a cycle where its input stream pulses. At divide by 1 the input stream passes straight through, so a continuously high source gives a continuously high enable.
- R8: A new prescaler code takes effect only after the divider's current period completes. The interval running when the code changes keeps its old length.
- R9: A synchronous active-high reset clears all divider counters, selects the internal oscillator and puts every divider at 1:1. While reset is held, every output follows `src_en[0]`. Each divider loads the configured code at its first period boundary after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 32 | Configuration word: source select, high-speed code, two peripheral codes |
| src_en | input | 3 | Source enable streams: internal, external, synthesized |
| hbus_en | output | 1 | High-speed bus enable pulse |
| pbus1_en | output | 1 | First peripheral bus enable pulse |
| pbus2_en | output | 1 | Second peripheral bus enable pulse |
| ptim1_en | output | 1 | First peripheral bus timer enable pulse |
| ptim2_en | output | 1 | Second peripheral bus timer enable pulse |

## Verification
The three source streams run at full, half and one-third rate at the same time. A pulse count over a fixed window therefore shows which source is selected, and shows that the reserved select code keeps the old one. The configurations cover the divide-by-1 code range, the codes on both sides of the missing divide-by-32 step, the deepest settings, and peripheral codes with the top bit set and clear. Each window is a whole number of periods, so every one of the five counts is exact and a wrong ratio or a missing timer doubling shows up directly. A scoreboard of expected pulse intervals, taken across a change from divide-by-512 to divide-by-2 in the middle of a period, separates a deferred change from an immediate one.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  localparam int CFG_W    = 32;
  localparam int SEL_LO   = 0;
  localparam int SEL_W    = 2;
  localparam int HS_LO    = 4;
  localparam int HS_W     = 4;
  localparam int PB_LO    = 10;
  localparam int PB_W     = 3;
  localparam int NUM_PB   = 2;
  localparam int SHIFT_W  = 4;

  // high-speed code -> log2(divide); the 32 step is absent
  function automatic logic [SHIFT_W-1:0] hs_shift(input logic [HS_W-1:0] code);
    if (!code[HS_W-1])
      return '0;
    else if (code[HS_W-2])
      return SHIFT_W'(code[1:0]) + SHIFT_W'(6);
    else
      return SHIFT_W'(code[1:0]) + SHIFT_W'(1);
  endfunction

  // peripheral code -> log2(divide)
  function automatic logic [SHIFT_W-1:0] pb_shift(input logic [PB_W-1:0] code);
    if (!code[PB_W-1])
      return '0;
    else
      return SHIFT_W'(code[1:0]) + SHIFT_W'(1);
  endfunction
endpackage

// File: rtl/bpt_src_sel.sv
module bpt_src_sel #(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   sel_req,
  input  logic [NUM_SRC-1:0] src_en,
  output logic               sys_en
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)
      sel_q <= '0;
    else if (int'(sel_req) < NUM_SRC)
      sel_q <= sel_req;
  end

  always_comb begin
    sys_en = 1'b0;
    for (int i = 0; i < NUM_SRC; i++)
      if (sel_q == SEL_W'(i)) sys_en = src_en[i];
  end
endmodule

// File: rtl/bpt_stage.sv
module bpt_stage #(
  parameter int SHIFT_W = 4,
  parameter int CNT_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_in,
  input  logic [SHIFT_W-1:0] shift_req,
  output logic               tick_out,
  output logic               tick_half
);
  logic [SHIFT_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   lim;
  logic [CNT_W-1:0]   half_mask;
  logic               wrap;

  assign lim       = ~({CNT_W{1'b1}} << shift_q);
  assign half_mask = lim >> 1;
  assign wrap      = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      shift_q <= '0;
    end else if (tick_in) begin
      if (wrap) begin
        cnt_q   <= '0;
        shift_q <= shift_req;
      end else begin
        cnt_q   <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign tick_out  = tick_in & wrap;
  assign tick_half = tick_in & ((cnt_q & half_mask) == half_mask);
endmodule

// File: rtl/busclk_prescale_tree.sv
module busclk_prescale_tree
  import bpt_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int CNT_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CFG_W-1:0]   cfg_word,
  input  logic [NUM_SRC-1:0] src_en,
  output logic               hbus_en,
  output logic               pbus1_en,
  output logic               pbus2_en,
  output logic               ptim1_en,
  output logic               ptim2_en
);
  logic              sys_en;
  logic              hs_half_unused;
  logic [NUM_PB-1:0] pb_tick;
  logic [NUM_PB-1:0] pb_tim;
  logic              unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_word[31:16], cfg_word[9:8], cfg_word[3:2]};

  bpt_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .sel_req (cfg_word[SEL_LO +: SEL_W]),
    .src_en  (src_en),
    .sys_en  (sys_en)
  );

  bpt_stage #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) u_hs (
    .clk       (clk),
    .rst       (rst),
    .tick_in   (sys_en),
    .shift_req (hs_shift(cfg_word[HS_LO +: HS_W])),
    .tick_out  (hbus_en),
    .tick_half (hs_half_unused)
  );

  for (genvar g = 0; g < NUM_PB; g++) begin : g_pb
    localparam int LO = PB_LO + g * PB_W;
    bpt_stage #(.SHIFT_W(SHIFT_W), .CNT_W(CNT_W)) u_pb (
      .clk       (clk),
      .rst       (rst),
      .tick_in   (hbus_en),
      .shift_req (pb_shift(cfg_word[LO +: PB_W])),
      .tick_out  (pb_tick[g]),
      .tick_half (pb_tim[g])
    );
  end

  assign pbus1_en = pb_tick[0];
  assign pbus2_en = pb_tick[1];
  assign ptim1_en = pb_tim[0];
  assign ptim2_en = pb_tim[1];
endmodule

// File: rtl/bpt_chk.sv
module bpt_chk #(
  parameter int NUM_SRC = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_en,
  input logic               hbus_en,
  input logic               pbus1_en,
  input logic               pbus2_en,
  input logic               ptim1_en,
  input logic               ptim2_en
);
  // R6: every bus pulse is also a timer pulse
  p_tim_covers_bus_r6: assert property (@(posedge clk) disable iff (rst)
    (pbus1_en |-> ptim1_en) and (pbus2_en |-> ptim2_en));

  // R5: peripheral strobes only on high-speed strobes
  p_pbus_on_hbus_r5: assert property (@(posedge clk) disable iff (rst)
    (pbus1_en || pbus2_en || ptim1_en || ptim2_en) |-> hbus_en);

  // R7: high-speed strobe only when some source pulses
  p_hbus_on_src_r7: assert property (@(posedge clk) disable iff (rst)
    hbus_en |-> (src_en != '0));

  // R9: held reset passes the internal stream through everywhere
  p_reset_pass_r9: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (hbus_en == src_en[0] && pbus1_en == src_en[0]
                             && ptim2_en == src_en[0]));
endmodule

bind busclk_prescale_tree bpt_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src_en   (src_en),
  .hbus_en  (hbus_en),
  .pbus1_en (pbus1_en),
  .pbus2_en (pbus2_en),
  .ptim1_en (ptim1_en),
  .ptim2_en (ptim2_en)
);

// File: tb/busclk_prescale_tree_tb.sv
module busclk_prescale_tree_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] cfg_word = '0;
  logic [2:0]  src_en = 3'b001;
  logic        hbus_en, pbus1_en, pbus2_en, ptim1_en, ptim2_en;

  int checks = 0;
  int errors = 0;
  int cyc_n = 0;
  int last_pulse = 0;
  bit sb_on = 1'b0;
  bit done = 1'b0;
  int exp_q[$];
  logic ph2 = 1'b0;
  int   ph3 = 0;

  always #2 clk = ~clk;

  busclk_prescale_tree u_dut (
    .clk(clk), .rst(rst), .cfg_word(cfg_word), .src_en(src_en),
    .hbus_en(hbus_en), .pbus1_en(pbus1_en), .pbus2_en(pbus2_en),
    .ptim1_en(ptim1_en), .ptim2_en(ptim2_en)
  );

  // source streams: full, half, one-third rate
  initial forever begin
    @(posedge clk);
    #1;
    ph2 = ~ph2;
    ph3 = (ph3 == 2) ? 0 : ph3 + 1;
    src_en = {ph3 == 0, ph2, 1'b1};
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor for high-speed pulse intervals
  always @(negedge clk) begin
    cyc_n++;
    if (hbus_en) begin
      if (sb_on && exp_q.size() > 0) chk("R8 interval", cyc_n - last_pulse, exp_q.pop_front());
      last_pulse = cyc_n;
    end
  end

  function automatic logic [31:0] mk(int sel, int hs, int p1, int p2);
    logic [31:0] v = '0;
    v[1:0] = sel[1:0];
    v[7:4] = hs[3:0];
    v[12:10] = p1[2:0];
    v[15:13] = p2[2:0];
    return v;
  endfunction

  function automatic int hdiv(int c);
    if (c < 8) return 1;
    if (c < 12) return 1 << (c - 7);
    return 1 << (c - 6);
  endfunction

  function automatic int pdiv(int c);
    return (c < 4) ? 1 : (1 << (c - 3));
  endfunction

  task automatic set_cfg(logic [31:0] v);
    @(posedge clk);
    #1 cfg_word = v;
  endtask

  // speriod: cycles per pulse of the source in use
  task automatic run(string tag, int sel, int speriod, int hs, int p1, int p2,
                     int settle, int len);
    int c[5];
    int hp, pp1, pp2, tp1, tp2;
    c = '{0, 0, 0, 0, 0};
    set_cfg(mk(sel, hs, p1, p2));
    repeat (settle) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      c[0] += int'(hbus_en);
      c[1] += int'(pbus1_en);
      c[2] += int'(pbus2_en);
      c[3] += int'(ptim1_en);
      c[4] += int'(ptim2_en);
    end
    hp  = speriod * hdiv(hs);
    pp1 = hp * pdiv(p1);
    pp2 = hp * pdiv(p2);
    tp1 = (pdiv(p1) > 1) ? pp1 / 2 : pp1;
    tp2 = (pdiv(p2) > 1) ? pp2 / 2 : pp2;
    chk({tag, " hbus R3/R4/R1"}, c[0], len / hp);
    chk({tag, " pbus1 R5"}, c[1], len / pp1);
    chk({tag, " pbus2 R5"}, c[2], len / pp2);
    chk({tag, " tim1 R6"}, c[3], len / tp1);
    chk({tag, " tim2 R6"}, c[4], len / tp2);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: held reset follows the internal stream despite a deep config
    cfg_word = mk(1, 15, 7, 7);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R9 reset hbus", int'(hbus_en), int'(src_en[0]));
      chk("R9 reset tim2", int'(ptim2_en), int'(src_en[0]));
    end
    set_cfg(mk(0, 0, 0, 0));
    @(posedge clk);
    #1 rst = 1'b0;

    // R7/R1: internal source, all 1:1 -> continuous enables
    run("all-1:1 R7", 0, 1, 0, 0, 0, 8, 64);
    // R1 external source, high-speed /4, bus1 /4, bus2 1:1
    run("ext R1", 1, 2, 9, 5, 2, 100, 1024);
    // R2: reserved select keeps the external source
    run("reserved sel R2", 3, 2, 9, 5, 2, 100, 1024);
    // R1 synthesized source, /64 (R4), bus1 /16, bus2 /2
    run("pll R4", 2, 3, 12, 7, 4, 7000, 6144);
    // R4 deepest /512, bus1 /2, bus2 /8
    run("deep R4", 0, 1, 15, 4, 6, 9000, 8192);
    // R3 /16 edge below the missing /32 step
    run("div16 R3", 0, 1, 11, 0, 0, 1000, 256);
    // R3 code 7 still 1:1, bus code 3 still 1:1
    run("code7 R3", 0, 1, 7, 3, 0, 40, 64);

    // R8: change /512 -> /2 mid-period via scoreboard
    set_cfg(mk(0, 15, 0, 0));
    repeat (1000) @(negedge clk);
    @(negedge clk);
    while (!hbus_en) @(negedge clk);
    #1;
    exp_q.push_back(512);
    exp_q.push_back(2);
    exp_q.push_back(2);
    exp_q.push_back(2);
    sb_on = 1'b1;
    repeat (10) @(posedge clk);
    #1 cfg_word = mk(0, 8, 0, 0);
    repeat (600) @(negedge clk);
    chk("R8 scoreboard drained", exp_q.size(), 0);
    sb_on = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule